// File: doc/BRIEF.md
# Per-Bank Run-Length Activity Monitor

This block observes a vector of per-bank access strobes, one bit for each bank in every clock cycle, and turns it into run-length statistics. For each bank it separates busy runs (consecutive cycles with the strobe high) from quiet runs (consecutive cycles with the strobe low). For both kinds it keeps how many runs have finished, the total of their lengths and the longest one seen. A run is only recorded once both of its ends have been observed, so a run that was already in progress when observation began never contributes.

Alongside the run statistics, a free-running window timer splits time into fixed windows of 8192 cycles. Each bank counts its busy cycles inside the current window, and at the end of the window that count is copied to an output register and the counter restarts. This gives a per-window activity density for each bank. A single-cycle clear input wipes all statistics, restarts the window and makes every bank's current run unbounded again. All statistic registers saturate at their all-ones value.

Top module: `bank_run_monitor`

## Requirements
- R1: After reset, and in the cycle after a cycle with `clear` high, every count, sum, maximum and window output is zero.
- R2: When a bank's strobe is high for a bounded run of L cycles and then low, the busy count of that bank rises by one and its busy sum by L, visible in the cycle after the first low cycle; a single-cycle pulse gives L = 1.
- R3: When a bank's strobe is low for a bounded run of L cycles and then high, the quiet count rises by one and the quiet sum by L, visible in the cycle after the first high cycle.
- R4: The run in progress in the first cycle after reset or after a clear cycle is unbounded and is never recorded; only runs that start on a change of the strobe are recorded.
- R5: Within one bank, while neither count is saturated, the busy count and the quiet count differ by at most one.
- R6: A busy or quiet maximum takes the length of a completed run of its kind when that length exceeds the stored value, and otherwise keeps its value.
- R7: Run lengths, counts and sums saturate at all-ones instead of wrapping; a run longer than the length range is recorded with the all-ones length.
- R8: Windows are WINDOW cycles long (default 8192), the first beginning with the first cycle after reset or after a clear cycle; at the end of each window a bank's output shows the number of its busy cycles in that window, and the count for the next window starts at zero.
- R9: A clear cycle is not counted into any window or run, and a run completing in a clear cycle is discarded.
- R10: The banks are independent: the statistics of one bank depend only on that bank's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Wipe statistics and restart observation |
| bank_en | input | NUM_BANKS | Per-bank access strobe for this cycle |
| act_count | output | NUM_BANKS x CNT_W | Completed busy runs per bank |
| act_sum | output | NUM_BANKS x SUM_W | Total length of completed busy runs |
| act_max | output | NUM_BANKS x LEN_W | Longest completed busy run |
| idle_count | output | NUM_BANKS x CNT_W | Completed quiet runs per bank |
| idle_sum | output | NUM_BANKS x SUM_W | Total length of completed quiet runs |
| idle_max | output | NUM_BANKS x LEN_W | Longest completed quiet run |
| win_active | output | NUM_BANKS x ACC_W | Busy cycles per bank in the last finished window |

## Verification
Two events can share one cycle: a strobe change that completes a run can fall on the same cycle as a clear, and a window boundary can fall on a cycle where a bank's strobe changes or is high. Random stimulus with shifting busy densities and occasional clears hits both coincidences many times, and directed sequences force a window end with a known busy count. A cycle-level reference model written from the requirements predicts every output after each edge and judges whether the clear discarded the completing run and whether the boundary cycle was counted into the closing window.

// File: rtl/brm_pkg.sv
package brm_pkg;
   localparam int unsigned BRM_DEFAULT_WINDOW = 8192;

   typedef enum logic {
      RUN_QUIET = 1'b0,
      RUN_BUSY  = 1'b1
   } run_kind_e;
endpackage

// File: rtl/brm_run_tracker.sv
module brm_run_tracker
   import brm_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   output logic             busy_done,
   output logic             quiet_done,
   output logic [LEN_W-1:0] done_len
);
   localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

   run_kind_e        cur_kind;
   logic             started;
   logic             bounded;
   logic [LEN_W-1:0] run_len;
   logic             change;

   assign change     = started && !clear && (run_kind_e'(en) != cur_kind);
   assign busy_done  = change && bounded && (cur_kind == RUN_BUSY);
   assign quiet_done = change && bounded && (cur_kind == RUN_QUIET);
   assign done_len   = run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         bounded  <= 1'b0;
         cur_kind <= RUN_QUIET;
         run_len  <= '0;
      end else if (clear || !started) begin
         started  <= 1'b1;
         bounded  <= 1'b0;
         cur_kind <= run_kind_e'(en);
         run_len  <= LEN_W'(1);
      end else if (change) begin
         bounded  <= 1'b1;
         cur_kind <= run_kind_e'(en);
         run_len  <= LEN_W'(1);
      end else if (run_len != LEN_MAX) begin
         run_len  <= run_len + 1'b1;
      end
   end
endmodule

// File: rtl/brm_stat_accum.sv
module brm_stat_accum #(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned SUM_W = 32,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             done,
   input  logic [LEN_W-1:0] len,
   output logic [CNT_W-1:0] count,
   output logic [SUM_W-1:0] total,
   output logic [LEN_W-1:0] longest
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};

   logic [SUM_W:0] sum_wide;
   assign sum_wide = {1'b0, total} + (SUM_W+1)'(len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         total   <= '0;
         longest <= '0;
      end else if (clear) begin
         count   <= '0;
         total   <= '0;
         longest <= '0;
      end else if (done) begin
         if (count != CNT_MAX) count <= count + 1'b1;
         total <= sum_wide[SUM_W] ? SUM_MAX : sum_wide[SUM_W-1:0];
         if (len > longest) longest <= len;
      end
   end
endmodule

// File: rtl/brm_window.sv
module brm_window #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WINDOW    = 8192,
   parameter int unsigned ACC_W     = $clog2(WINDOW + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic [NUM_BANKS-1:0]            en,
   output logic [NUM_BANKS-1:0][ACC_W-1:0] latched
);
   localparam int unsigned WCNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam logic [WCNT_W-1:0] LAST = WCNT_W'(WINDOW - 1);

   logic [WCNT_W-1:0] wcnt;
   logic              wrap;

   assign wrap = (wcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wcnt <= '0;
      else if (clear || wrap) wcnt <= '0;
      else                 wcnt <= wcnt + 1'b1;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] acc_next;
      assign acc_next = acc + ACC_W'(en[b]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc        <= '0;
            latched[b] <= '0;
         end else if (clear) begin
            acc        <= '0;
            latched[b] <= '0;
         end else if (wrap) begin
            acc        <= '0;
            latched[b] <= acc_next;
         end else begin
            acc        <= acc_next;
         end
      end
   end
endmodule

// File: rtl/bank_run_monitor.sv
module bank_run_monitor
   import brm_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned SUM_W     = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned WINDOW    = BRM_DEFAULT_WINDOW,
   parameter int unsigned ACC_W     = $clog2(WINDOW + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic [NUM_BANKS-1:0]            bank_en,
   output logic [NUM_BANKS-1:0][CNT_W-1:0] act_count,
   output logic [NUM_BANKS-1:0][SUM_W-1:0] act_sum,
   output logic [NUM_BANKS-1:0][LEN_W-1:0] act_max,
   output logic [NUM_BANKS-1:0][CNT_W-1:0] idle_count,
   output logic [NUM_BANKS-1:0][SUM_W-1:0] idle_sum,
   output logic [NUM_BANKS-1:0][LEN_W-1:0] idle_max,
   output logic [NUM_BANKS-1:0][ACC_W-1:0] win_active
);
   initial begin
      if (NUM_BANKS < 1)      $fatal(1, "NUM_BANKS must be at least 1");
      if (LEN_W < 2)          $fatal(1, "LEN_W must be at least 2");
      if (SUM_W < LEN_W)      $fatal(1, "SUM_W must not be narrower than LEN_W");
      if (CNT_W < 1)          $fatal(1, "CNT_W must be at least 1");
      if (WINDOW < 2)         $fatal(1, "WINDOW must be at least 2");
      if (ACC_W < $clog2(WINDOW + 1)) $fatal(1, "ACC_W too narrow for WINDOW");
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             busy_done;
      logic             quiet_done;
      logic [LEN_W-1:0] done_len;

      brm_run_tracker #(.LEN_W(LEN_W)) u_track (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (clear),
         .en         (bank_en[b]),
         .busy_done  (busy_done),
         .quiet_done (quiet_done),
         .done_len   (done_len)
      );

      brm_stat_accum #(.LEN_W(LEN_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_busy (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clear),
         .done    (busy_done),
         .len     (done_len),
         .count   (act_count[b]),
         .total   (act_sum[b]),
         .longest (act_max[b])
      );

      brm_stat_accum #(.LEN_W(LEN_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_quiet (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clear),
         .done    (quiet_done),
         .len     (done_len),
         .count   (idle_count[b]),
         .total   (idle_sum[b]),
         .longest (idle_max[b])
      );
   end

   brm_window #(.NUM_BANKS(NUM_BANKS), .WINDOW(WINDOW), .ACC_W(ACC_W)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .en      (bank_en),
      .latched (win_active)
   );
endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned SUM_W     = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned WINDOW    = 8192,
   parameter int unsigned ACC_W     = 14
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            clear,
   input logic [NUM_BANKS-1:0]            bank_en,
   input logic [NUM_BANKS-1:0][CNT_W-1:0] act_count,
   input logic [NUM_BANKS-1:0][SUM_W-1:0] act_sum,
   input logic [NUM_BANKS-1:0][LEN_W-1:0] act_max,
   input logic [NUM_BANKS-1:0][CNT_W-1:0] idle_count,
   input logic [NUM_BANKS-1:0][SUM_W-1:0] idle_sum,
   input logic [NUM_BANKS-1:0][LEN_W-1:0] idle_max,
   input logic [NUM_BANKS-1:0][ACC_W-1:0] win_active
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      logic signed [CNT_W+1:0] diff;
      assign diff = $signed({2'b00, act_count[b]}) - $signed({2'b00, idle_count[b]});

      assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> (act_count[b] == '0 && idle_count[b] == '0 && act_sum[b] == '0 &&
                    idle_sum[b] == '0 && win_active[b] == '0));

      assert_busy_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(clear) && act_count[b] != $past(act_count[b]))
            |-> (!$past(bank_en[b]) && $past(bank_en[b], 2)));

      assert_quiet_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(clear) && idle_count[b] != $past(idle_count[b]))
            |-> ($past(bank_en[b]) && !$past(bank_en[b], 2)));

      assert_balance_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (act_count[b] != CNT_MAX && idle_count[b] != CNT_MAX)
            |-> (diff <= 1 && diff >= -1));

      assert_max_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !clear |=> (act_max[b] >= $past(act_max[b]) && idle_max[b] >= $past(idle_max[b])));

      assert_sum_covers_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (SUM_W'(act_max[b]) <= act_sum[b]) && (SUM_W'(idle_max[b]) <= idle_sum[b]));

      assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
         win_active[b] <= ACC_W'(WINDOW));
   end
endmodule

bind bank_run_monitor brm_checker #(
   .NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W), .SUM_W(SUM_W),
   .CNT_W(CNT_W), .WINDOW(WINDOW), .ACC_W(ACC_W)
) u_brm_checker (.*);

// File: tb/test_bank_run_monitor.sv
module test_bank_run_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int NB     = 4;
   localparam int LEN_W  = 6;
   localparam int SUM_W  = 8;
   localparam int CNT_W  = 5;
   localparam int WINDOW = 8192;
   localparam int ACC_W  = $clog2(WINDOW + 1);
   localparam int LMAX = (1 << LEN_W) - 1;
   localparam int SMAX = (1 << SUM_W) - 1;
   localparam int CMAX = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear = 1'b0;
   logic [NB-1:0] bank_en = '0;
   logic [NB-1:0][CNT_W-1:0] act_count, idle_count;
   logic [NB-1:0][SUM_W-1:0] act_sum, idle_sum;
   logic [NB-1:0][LEN_W-1:0] act_max, idle_max;
   logic [NB-1:0][ACC_W-1:0] win_active;

   int n_checks = 0;
   int n_fails  = 0;

   bank_run_monitor #(.NUM_BANKS(NB), .LEN_W(LEN_W), .SUM_W(SUM_W),
                      .CNT_W(CNT_W), .WINDOW(WINDOW)) i_bank_run_monitor (
      .clk(clk), .rst_n(rst_n), .clear(clear), .bank_en(bank_en),
      .act_count(act_count), .act_sum(act_sum), .act_max(act_max),
      .idle_count(idle_count), .idle_sum(idle_sum), .idle_max(idle_max),
      .win_active(win_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   int m_started [NB];
   int m_prev [NB];
   int m_len [NB];
   int m_bnd [NB];
   int m_cnt [2][NB];
   int m_sum [2][NB];
   int m_max [2][NB];
   int m_acc [NB];
   int m_win [NB];
   int m_wcnt;

   function automatic int sat(input int v, input int lim);
      return (v > lim) ? lim : v;
   endfunction

   task automatic model_reset();
      m_wcnt = 0;
      for (int b = 0; b < NB; b++) begin
         m_started[b] = 0; m_prev[b] = 0; m_len[b] = 0; m_bnd[b] = 0;
         m_acc[b] = 0; m_win[b] = 0;
         for (int k = 0; k < 2; k++) begin
            m_cnt[k][b] = 0; m_sum[k][b] = 0; m_max[k][b] = 0;
         end
      end
   endtask

   task automatic model_step(input logic [NB-1:0] en, input logic clr);
      int wrap;
      wrap = (m_wcnt == WINDOW - 1);
      for (int b = 0; b < NB; b++) begin
         int e;
         e = int'(en[b]);
         if (clr) begin
            for (int k = 0; k < 2; k++) begin
               m_cnt[k][b] = 0; m_sum[k][b] = 0; m_max[k][b] = 0;
            end
            m_started[b] = 1; m_prev[b] = e; m_len[b] = 1; m_bnd[b] = 0;
            m_acc[b] = 0; m_win[b] = 0;
         end else begin
            if (!m_started[b]) begin
               m_started[b] = 1; m_prev[b] = e; m_len[b] = 1; m_bnd[b] = 0;
            end else if (e != m_prev[b]) begin
               if (m_bnd[b]) begin
                  int k;
                  k = m_prev[b];
                  m_cnt[k][b] = sat(m_cnt[k][b] + 1, CMAX);
                  m_sum[k][b] = sat(m_sum[k][b] + m_len[b], SMAX);
                  if (m_len[b] > m_max[k][b]) m_max[k][b] = m_len[b];
               end
               m_prev[b] = e; m_len[b] = 1; m_bnd[b] = 1;
            end else begin
               m_len[b] = sat(m_len[b] + 1, LMAX);
            end
            if (wrap) begin
               m_win[b] = m_acc[b] + e; m_acc[b] = 0;
            end else begin
               m_acc[b] = m_acc[b] + e;
            end
         end
      end
      if (clr || wrap) m_wcnt = 0;
      else m_wcnt = m_wcnt + 1;
   endtask

   task automatic check(input string req, input string what, input int b,
                        input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fails++;
         $display("FAIL %s %s bank %0d: actual %0d expected %0d", req, what, b, actual, expected);
      end
   endtask

   task automatic compare_all();
      for (int b = 0; b < NB; b++) begin
         check("R2", "busy count", b, int'(act_count[b]), m_cnt[1][b]);
         check("R2", "busy sum",   b, int'(act_sum[b]),   m_sum[1][b]);
         check("R6", "busy max",   b, int'(act_max[b]),   m_max[1][b]);
         check("R3", "quiet count", b, int'(idle_count[b]), m_cnt[0][b]);
         check("R3", "quiet sum",   b, int'(idle_sum[b]),   m_sum[0][b]);
         check("R6", "quiet max",   b, int'(idle_max[b]),   m_max[0][b]);
         check("R8", "window",      b, int'(win_active[b]), m_win[b]);
      end
   endtask

   task automatic cyc(input logic [NB-1:0] en, input logic clr);
      bank_en = en;
      clear   = clr;
      @(posedge clk);
      model_step(en, clr);
      @(negedge clk);
      compare_all();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int b = 0; b < NB; b++) begin
         check("R1", "reset busy count", b, int'(act_count[b]), 0);
         check("R1", "reset window", b, int'(win_active[b]), 0);
      end
      rst_n = 1'b1;

      // R2 R3 R4 R6 R10: bank0 pattern 0 0 1 0 0 1 1 1 0, bank1 always high
      cyc(4'b0010, 0); cyc(4'b0010, 0); cyc(4'b0011, 0);
      check("R4", "leading quiet run dropped", 0, int'(idle_count[0]), 0);
      cyc(4'b0010, 0);
      check("R2", "single pulse length one", 0, int'(act_sum[0]), 1);
      cyc(4'b0010, 0); cyc(4'b0011, 0);
      check("R3", "quiet run of two", 0, int'(idle_sum[0]), 2);
      cyc(4'b0011, 0); cyc(4'b0011, 0); cyc(4'b0010, 0);
      check("R6", "busy max three", 0, int'(act_max[0]), 3);
      check("R2", "busy sum four", 0, int'(act_sum[0]), 4);
      check("R4", "open busy run not counted", 1, int'(act_count[1]), 0);
      check("R10", "idle bank untouched", 2, int'(act_count[2]) + int'(idle_count[2]), 0);

      // R9 R1: clear discards a run completing in the clear cycle
      cyc(4'b0011, 0);
      cyc(4'b0010, 1);
      check("R9", "completion in clear cycle dropped", 0, int'(act_count[0]), 0);
      check("R1", "clear zeroes quiet sum", 0, int'(idle_sum[0]), 0);

      // R7: saturation of counts, length and sum
      for (int i = 0; i < 80; i++) cyc({2'b00, 1'(i % 2), 1'b0}, 0);
      check("R7", "busy count saturates", 1, int'(act_count[1]), CMAX);
      cyc('0, 0);
      for (int r = 0; r < 5; r++) begin
         for (int i = 0; i < 100; i++) cyc(4'b1000, 0);
         cyc(4'b0000, 0);
         cyc(4'b0000, 0);
      end
      check("R7", "busy length saturates", 3, int'(act_max[3]), LMAX);
      check("R7", "busy sum saturates", 3, int'(act_sum[3]), SMAX);

      // R8: a window with exactly 100 busy cycles on bank0
      cyc('0, 1);
      check("R9", "window cleared", 0, int'(win_active[0]), 0);
      for (int i = 0; i < WINDOW; i++) cyc((i < 100) ? 4'b0001 : 4'b0000, 0);
      check("R8", "window busy total", 0, int'(win_active[0]), 100);
      check("R8", "window quiet bank", 1, int'(win_active[1]), 0);

      // random phases with shifting density and rare clears
      for (int ph = 0; ph < 40; ph++) begin
         int dens;
         dens = (ph % 3 == 0) ? 10 : ((ph % 3 == 1) ? 50 : 90);
         for (int i = 0; i < 500; i++) begin
            logic [NB-1:0] e;
            logic c;
            for (int b = 0; b < NB; b++) e[b] = (($urandom % 100) < dens);
            c = (($urandom % 400) == 0);
            cyc(e, c);
         end
      end
      finish_run();
   end
endmodule